// File: doc/BRIEF.md
# Quasi-Bidirectional Port Register

This block is an eight-pin general-purpose port of the kind used by small 8-bit controllers. Each pin has a storage latch. A CPU-side bus can read the port in two ways: one select returns the synchronized level seen on the external pins, and the other returns the latch contents. The bus updates the latch through two separate write strobes. The byte strobe applies a load or an arithmetic/logic update to the whole latch. The bit strobe loads, sets, clears or complements one pin's latch and leaves the other seven untouched. Every update is computed from the latch and never from the pins.

On the pin side, a latch bit of 0 turns on a pull-down driver. A latch bit of 1 releases that driver. In the default variant, a released pin also enables a weak pull-up. In the open-drain variant (`OPEN_DRAIN=1`) the pull-up is never enabled, so a released pin is floating unless something outside holds it. A pin therefore works as an input only while its latch holds 1. Reset sets every latch to 1, so all pins start released.

The pins reach the read path through a two-flop synchronizer. Data read from the pins never writes back into the latch.

Top module: `qbport`

## Requirements
- R1: While reset is active and after it is released, every latch bit is 1: the latch reads FFh, `drive_low` is 00h, and, in the default variant, `pullup_en` is FFh.
- R2: The latch changes only in a cycle where `wr_byte_en` or `wr_bit_en` is high. Reading through either select leaves it unchanged.
- R3: `rd_latch_sel` high puts the latch on `rd_data`. `rd_pin_sel` high puts the synchronized pin level on `rd_data`. With neither select high, `rd_data` is 00h. The two selects are never high together.
- R4: The byte write code `wr_byte_op` is applied to the latch value, never to the pin value. The codes are 0 load data, 1 AND data, 2 OR data, 3 XOR data, 4 increment (FFh wraps to 00h) and 5 decrement (00h wraps to FFh).
- R5: The bit write code `wr_bit_op` acts only on latch bit `wr_bit_idx`. The codes are 0 load `wr_bit_val`, 1 set, 2 clear and 3 complement.
- R6: `drive_low[i]` is the inverse of latch bit i. A pin whose latch is 0 reads as 0 through the pin select, whatever an external source drives.
- R7: In the default variant, `pullup_en[i]` equals latch bit i. In the open-drain variant, `pullup_en` is always 00h. `drive_low` and `pullup_en` are never both high on the same pin.
- R8: When both write strobes are high in the same cycle, only the bit write is applied and the byte write is dropped.
- R9: A change on `pad_in` is visible through the pin select after exactly two rising clock edges, and not after one.
- R10: Byte write codes 6 and 7 leave the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_byte_en | input | 1 | Byte update strobe |
| wr_byte_op | input | 3 | Byte update code (R4, R10) |
| wr_byte_data | input | 8 | Byte operand |
| wr_bit_en | input | 1 | Single-bit update strobe |
| wr_bit_op | input | 2 | Bit update code (R5) |
| wr_bit_idx | input | 3 | Pin index for the bit update |
| wr_bit_val | input | 1 | Value for bit load |
| rd_pin_sel | input | 1 | Select synchronized pin level onto rd_data |
| rd_latch_sel | input | 1 | Select latch onto rd_data |
| rd_data | output | 8 | Read data |
| pad_in | input | 8 | Resolved logic level of the external pins |
| drive_low | output | 8 | Pull-down driver enable per pin |
| pullup_en | output | 8 | Weak pull-up enable per pin |

## Verification
The bench drives an external level of A5h onto the pins and then loads the latch with 0Fh. A design that read the pins back would return 05h instead of the latch value, and a design that let a driven-low pin read as the external level would show A5h on the pin path. Increment from FFh and decrement from 00h are checked for wrap-around. A carry that leaked past bit 7, or a byte update taken from the pins, would show the wrong latch value. When both strobes arrive together, the byte operand is chosen so that a design honouring it, or merging both updates, leaves a visibly different latch. The pin-path latency is checked one edge early and on time, so a synchronizer that is one flop short or one flop long fails.

// File: rtl/qbp_pkg.sv
package qbp_pkg;

    typedef enum logic [2:0] {
        BYTE_LOAD = 3'd0,
        BYTE_AND  = 3'd1,
        BYTE_OR   = 3'd2,
        BYTE_XOR  = 3'd3,
        BYTE_INC  = 3'd4,
        BYTE_DEC  = 3'd5,
        BYTE_NOP6 = 3'd6,
        BYTE_NOP7 = 3'd7
    } byte_op_e;

    typedef enum logic [1:0] {
        BIT_LOAD = 2'd0,
        BIT_SET  = 2'd1,
        BIT_CLR  = 2'd2,
        BIT_CPL  = 2'd3
    } bit_op_e;

endpackage

// File: rtl/qbp_sync.sv
module qbp_sync #(
    parameter int WIDTH       = 8,
    parameter int STAGES      = 2,
    parameter bit RESET_LEVEL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg[s] <= {WIDTH{RESET_LEVEL}};
            end
        end else begin
            stg[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/qbp_update.sv
module qbp_update
    import qbp_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             byte_en,
    input  logic [2:0]       byte_op,
    input  logic [WIDTH-1:0] byte_data,
    input  logic             bit_en,
    input  logic [1:0]       bit_op,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    output logic [WIDTH-1:0] nxt
);

    byte_op_e bop;
    bit_op_e  iop;

    assign bop = byte_op_e'(byte_op);
    assign iop = bit_op_e'(bit_op);

    always_comb begin
        nxt = cur;
        if (bit_en) begin
            unique case (iop)
                BIT_LOAD: nxt[bit_idx] = bit_val;
                BIT_SET:  nxt[bit_idx] = 1'b1;
                BIT_CLR:  nxt[bit_idx] = 1'b0;
                BIT_CPL:  nxt[bit_idx] = ~cur[bit_idx];
            endcase
        end else if (byte_en) begin
            unique case (bop)
                BYTE_LOAD: nxt = byte_data;
                BYTE_AND:  nxt = cur & byte_data;
                BYTE_OR:   nxt = cur | byte_data;
                BYTE_XOR:  nxt = cur ^ byte_data;
                BYTE_INC:  nxt = cur + {{(WIDTH-1){1'b0}}, 1'b1};
                BYTE_DEC:  nxt = cur - {{(WIDTH-1){1'b0}}, 1'b1};
                BYTE_NOP6: nxt = cur;
                BYTE_NOP7: nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/qbp_pad.sv
module qbp_pad #(
    parameter int WIDTH      = 8,
    parameter bit OPEN_DRAIN = 1'b0
) (
    input  logic [WIDTH-1:0] latch,
    output logic [WIDTH-1:0] drive_low,
    output logic [WIDTH-1:0] pullup_en
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign drive_low[i] = ~latch[i];
        if (OPEN_DRAIN) begin : g_od
            assign pullup_en[i] = 1'b0;
        end else begin : g_pu
            assign pullup_en[i] = latch[i];
        end
    end

endmodule

// File: rtl/qbport.sv
module qbport #(
    parameter int WIDTH       = 8,
    parameter bit OPEN_DRAIN  = 1'b0,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_byte_en,
    input  logic [2:0]       wr_byte_op,
    input  logic [WIDTH-1:0] wr_byte_data,
    input  logic             wr_bit_en,
    input  logic [1:0]       wr_bit_op,
    input  logic [IDX_W-1:0] wr_bit_idx,
    input  logic             wr_bit_val,
    input  logic             rd_pin_sel,
    input  logic             rd_latch_sel,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] drive_low,
    output logic [WIDTH-1:0] pullup_en
);

    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] latch_nxt;
    logic [WIDTH-1:0] pin_sync;

    qbp_update #(.WIDTH(WIDTH)) u_upd (
        .cur       (latch_q),
        .byte_en   (wr_byte_en),
        .byte_op   (wr_byte_op),
        .byte_data (wr_byte_data),
        .bit_en    (wr_bit_en),
        .bit_op    (wr_bit_op),
        .bit_idx   (wr_bit_idx),
        .bit_val   (wr_bit_val),
        .nxt       (latch_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '1;
        end else if (wr_byte_en || wr_bit_en) begin
            latch_q <= latch_nxt;
        end
    end

    qbp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES), .RESET_LEVEL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pin_sync)
    );

    qbp_pad #(.WIDTH(WIDTH), .OPEN_DRAIN(OPEN_DRAIN)) u_pad (
        .latch     (latch_q),
        .drive_low (drive_low),
        .pullup_en (pullup_en)
    );

    always_comb begin
        if (rd_latch_sel)     rd_data = latch_q;
        else if (rd_pin_sel)  rd_data = pin_sync;
        else                  rd_data = '0;
    end

endmodule

// File: rtl/qbport_chk.sv
module qbport_chk #(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_byte_en,
    input logic             wr_bit_en,
    input logic [IDX_W-1:0] wr_bit_idx,
    input logic             rd_pin_sel,
    input logic             rd_latch_sel,
    input logic [WIDTH-1:0] rd_data,
    input logic [WIDTH-1:0] pad_in,
    input logic [WIDTH-1:0] drive_low,
    input logic [WIDTH-1:0] pullup_en,
    input logic [WIDTH-1:0] latch_q
);

    logic [1:0] live_cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               live_cyc <= 2'd0;
        else if (live_cyc != 2'd3) live_cyc <= live_cyc + 2'd1;
    end

    AST_RESET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> latch_q == '1); // R1

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_byte_en && !wr_bit_en) |=> $stable(latch_q)); // R2

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_pin_sel && rd_latch_sel)); // R3

    AST_BIT_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bit_en |=> ((latch_q ^ $past(latch_q))
                       & ~({{(WIDTH-1){1'b0}}, 1'b1} << $past(wr_bit_idx))) == '0); // R5

    AST_DRIVE_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low == ~latch_q); // R6

    AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_low & pullup_en) == '0); // R7

    AST_PIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pin_sel && !rd_latch_sel && live_cyc >= 2'd2) |-> rd_data == $past(pad_in, 2)); // R9

endmodule

bind qbport qbport_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_byte_en   (wr_byte_en),
    .wr_bit_en    (wr_bit_en),
    .wr_bit_idx   (wr_bit_idx),
    .rd_pin_sel   (rd_pin_sel),
    .rd_latch_sel (rd_latch_sel),
    .rd_data      (rd_data),
    .pad_in       (pad_in),
    .drive_low    (drive_low),
    .pullup_en    (pullup_en),
    .latch_q      (latch_q)
);

// File: tb/sim_qbport.sv
module sim_qbport;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_byte_en = 1'b0;
    logic [2:0] wr_byte_op = 3'd0;
    logic [7:0] wr_byte_data = 8'h00;
    logic       wr_bit_en = 1'b0;
    logic [1:0] wr_bit_op = 2'd0;
    logic [2:0] wr_bit_idx = 3'd0;
    logic       wr_bit_val = 1'b0;
    logic       rd_pin_sel = 1'b0;
    logic       rd_latch_sel = 1'b0;
    logic [7:0] rd_data, drive_low, pullup_en, pad_in;
    logic [7:0] od_rd_data, od_drive_low, od_pullup_en, od_pad_in;
    logic [7:0] ext_en = 8'h00;
    logic [7:0] ext_val = 8'h00;
    logic [7:0] exp_latch;
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // external world: driver low wins, else external source, else pull-up
    assign pad_in    = ~drive_low & ((ext_en & ext_val) | (~ext_en & pullup_en));
    assign od_pad_in = ~od_drive_low; // open-drain copy sees an external pull-up

    qbport u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_byte_en(wr_byte_en), .wr_byte_op(wr_byte_op), .wr_byte_data(wr_byte_data),
        .wr_bit_en(wr_bit_en), .wr_bit_op(wr_bit_op), .wr_bit_idx(wr_bit_idx), .wr_bit_val(wr_bit_val),
        .rd_pin_sel(rd_pin_sel), .rd_latch_sel(rd_latch_sel), .rd_data(rd_data),
        .pad_in(pad_in), .drive_low(drive_low), .pullup_en(pullup_en)
    );

    qbport #(.OPEN_DRAIN(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n),
        .wr_byte_en(wr_byte_en), .wr_byte_op(wr_byte_op), .wr_byte_data(wr_byte_data),
        .wr_bit_en(wr_bit_en), .wr_bit_op(wr_bit_op), .wr_bit_idx(wr_bit_idx), .wr_bit_val(wr_bit_val),
        .rd_pin_sel(rd_pin_sel), .rd_latch_sel(rd_latch_sel), .rd_data(od_rd_data),
        .pad_in(od_pad_in), .drive_low(od_drive_low), .pullup_en(od_pullup_en)
    );

    function automatic logic [7:0] f_byte(input logic [7:0] cur, input logic [2:0] op, input logic [7:0] d);
        case (op)
            3'd0: return d;
            3'd1: return cur & d;
            3'd2: return cur | d;
            3'd3: return cur ^ d;
            3'd4: return cur + 8'd1;
            3'd5: return cur - 8'd1;
            default: return cur;
        endcase
    endfunction

    function automatic logic [7:0] f_bit(input logic [7:0] cur, input logic [1:0] op, input logic [2:0] idx, input logic v);
        logic [7:0] r;
        r = cur;
        case (op)
            2'd0: r[idx] = v;
            2'd1: r[idx] = 1'b1;
            2'd2: r[idx] = 1'b0;
            default: r[idx] = ~cur[idx];
        endcase
        return r;
    endfunction

    function automatic logic [7:0] f_pin(input logic [7:0] lat, input logic [7:0] en, input logic [7:0] val);
        return lat & ((en & val) | ~en);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    task automatic rd_latch(output logic [7:0] v);
        rd_latch_sel = 1'b1; #1; v = rd_data; rd_latch_sel = 1'b0; #1;
    endtask

    task automatic rd_pin(output logic [7:0] v);
        rd_pin_sel = 1'b1; #1; v = rd_data; rd_pin_sel = 1'b0; #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic be, input logic [2:0] bop, input logic [7:0] bd,
                      input logic ie, input logic [1:0] iop, input logic [2:0] idx, input logic iv);
        wr_byte_en = be; wr_byte_op = bop; wr_byte_data = bd;
        wr_bit_en = ie; wr_bit_op = iop; wr_bit_idx = idx; wr_bit_val = iv;
        if (ie)      exp_latch = f_bit(exp_latch, iop, idx, iv);
        else if (be) exp_latch = f_byte(exp_latch, bop, bd);
        @(posedge clk); @(negedge clk);
        wr_byte_en = 1'b0; wr_bit_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog all act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240517));
        exp_latch = 8'hFF;
        @(negedge clk); @(negedge clk);
        // R1 during reset
        rd_latch(v); chk("R1 latch in reset", v, 8'hFF);
        chk("R1 drive_low in reset", drive_low, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        idle(1);
        rd_latch(v); chk("R1 latch after reset", v, 8'hFF);
        chk("R1 pullup after reset", pullup_en, 8'hFF);
        chk("R3 no select reads zero", rd_data, 8'h00);

        // R9 exact two-edge latency
        ext_en = 8'hFF; ext_val = 8'hA5;
        idle(1);
        rd_pin(v); chk("R9 pin after one edge still old", v, 8'hFF);
        idle(1);
        rd_pin(v); chk("R9 pin after two edges", v, 8'hA5);

        // R6 driven-low pins read 0 regardless of external level
        wr(1'b1, 3'd0, 8'h0F, 1'b0, 2'd0, 3'd0, 1'b0);
        chk("R6 drive_low inverse", drive_low, 8'hF0);
        idle(2);
        rd_pin(v); chk("R6 pin read masked by low latch", v, 8'h05);
        // R2 pin read did not touch latch
        rd_latch(v); chk("R2 latch unchanged by pin read", v, 8'h0F);
        chk("R7 pullup follows latch", pullup_en, 8'h0F);
        chk("R7 open-drain pullup off", od_pullup_en, 8'h00);

        // R4 byte updates from latch, not pins (pins still A5 outside)
        wr(1'b1, 3'd1, 8'h3C, 1'b0, 2'd0, 3'd0, 1'b0);
        rd_latch(v); chk("R4 AND", v, 8'h0C);
        wr(1'b1, 3'd2, 8'h50, 1'b0, 2'd0, 3'd0, 1'b0);
        rd_latch(v); chk("R4 OR", v, 8'h5C);
        wr(1'b1, 3'd3, 8'hFF, 1'b0, 2'd0, 3'd0, 1'b0);
        rd_latch(v); chk("R4 XOR", v, 8'hA3);
        wr(1'b1, 3'd0, 8'hFF, 1'b0, 2'd0, 3'd0, 1'b0);
        wr(1'b1, 3'd4, 8'h00, 1'b0, 2'd0, 3'd0, 1'b0);
        rd_latch(v); chk("R4 INC wrap", v, 8'h00);
        wr(1'b1, 3'd5, 8'h00, 1'b0, 2'd0, 3'd0, 1'b0);
        rd_latch(v); chk("R4 DEC wrap", v, 8'hFF);
        // R10 reserved codes
        wr(1'b1, 3'd6, 8'h00, 1'b0, 2'd0, 3'd0, 1'b0);
        wr(1'b1, 3'd7, 8'h12, 1'b0, 2'd0, 3'd0, 1'b0);
        rd_latch(v); chk("R10 reserved codes hold", v, 8'hFF);

        // R5 bit updates
        wr(1'b0, 3'd0, 8'h00, 1'b1, 2'd2, 3'd7, 1'b0);
        rd_latch(v); chk("R5 clear bit7", v, 8'h7F);
        wr(1'b0, 3'd0, 8'h00, 1'b1, 2'd3, 3'd0, 1'b0);
        rd_latch(v); chk("R5 complement bit0", v, 8'h7E);
        wr(1'b0, 3'd0, 8'h00, 1'b1, 2'd1, 3'd7, 1'b0);
        rd_latch(v); chk("R5 set bit7", v, 8'hFE);
        wr(1'b0, 3'd0, 8'h00, 1'b1, 2'd0, 3'd3, 1'b0);
        rd_latch(v); chk("R5 load bit3", v, 8'hF6);

        // R8 bit write beats byte write
        wr(1'b1, 3'd0, 8'h00, 1'b1, 2'd1, 3'd0, 1'b0);
        rd_latch(v); chk("R8 bit wins over byte", v, 8'hF7);
        chk("R7 open-drain drive_low", od_drive_low, 8'h08);

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [7:0] lv, pv;
            ext_en  = 8'($urandom);
            ext_val = 8'($urandom);
            wr(1'($urandom), 3'($urandom), 8'($urandom),
               1'($urandom), 2'($urandom), 3'($urandom), 1'($urandom));
            idle(2);
            rd_latch(lv); chk("R4 R5 R8 random latch", lv, exp_latch);
            rd_pin(pv);   chk("R6 R9 random pin", pv, f_pin(exp_latch, ext_en, ext_val));
            chk("R6 random drive_low", drive_low, ~exp_latch);
            chk("R7 random pullup", pullup_en, exp_latch);
            chk("R7 random open-drain pullup", od_pullup_en, 8'h00);
            rd_latch(lv); chk("R2 random hold after reads", lv, exp_latch);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule